// File: doc/BRIEF.md
# Auto-Refresh Scheduler with Postponement

This block belongs to a DRAM memory controller. It keeps time for periodic auto-refresh and asks the command arbiter for a refresh slot. Each elapsed interval adds one refresh to a running debt. The arbiter may let that debt build up while read and write traffic is heavy, and then clear it with refreshes issued back to back. The debt never goes above a posting limit. When the debt reaches that limit, the block raises an urgent flag, and the arbiter must then serve refresh before any other traffic.

A refresh is taken only when the arbiter grants it, the request is raised and all banks are reported precharged. After each taken refresh the block holds a busy signal for the refresh cycle time.

A simple self-refresh mode is included. While the device is in self-refresh:
- the interval timer is frozen;
- the debt is cleared on entry.

On exit, one refresh is owed at once. Two blocking windows follow the exit:
- a short window during which non-read commands, including refresh, are held off;
- a longer window during which reads are held off.

Top module: `refresh_sched`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `ref_req`, `ref_urgent`, `ref_busy`, `sr_active`, `cmd_block` and `rd_block` are all low.
- R2: The debt rises by one every `TREFI_CYC` clock cycles, counting from reset release. The first increment lands on edge `TREFI_CYC+1` after release. `ref_req` is high whenever the debt is nonzero and nothing masks it. The masks are `ref_busy`, `cmd_block` and self-refresh.
- R3: A grant is taken only on an edge where `ref_grant`, `ref_req` and `all_idle` are all high. A grant taken on any other edge changes neither the debt nor `ref_busy`.
- R4: A taken grant lowers the debt by one. `ref_busy` then stays high for exactly `TRFC_CYC` cycles, starting the cycle after the grant. `ref_req` is low during that window, and grants that arrive during it are ignored.
- R5: The debt saturates at `MAX_DEBT` (8 by default), and interval ticks beyond that limit are dropped. `ref_urgent` is high exactly when the debt equals `MAX_DEBT`.
- R6: If an interval tick and a taken grant fall on the same edge, the debt is unchanged.
- R7: `sr_enter` is accepted only when all three hold: the block is not in self-refresh, `all_idle` is high, and both `ref_busy` and `cmd_block` are low. On acceptance, `sr_active` rises on the next cycle, the debt is cleared and the interval timer is frozen. `ref_req` stays low throughout self-refresh.
- R8: `sr_exit` during self-refresh has these effects:
  - `sr_active` drops.
  - `cmd_block` is high for `TXSNR_CYC` cycles and `rd_block` for `TXSRD_CYC` cycles, both starting the cycle after the exit.
  - The debt rises by one.
  - `ref_req` appears on the cycle `cmd_block` falls.
- R9: The interval timer restarts from zero on self-refresh exit. The next debt increment lands on edge `TREFI_CYC+1` after the exit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| all_idle | input | 1 | All banks are precharged |
| ref_grant | input | 1 | Arbiter grants the refresh slot |
| sr_enter | input | 1 | Request to enter self-refresh |
| sr_exit | input | 1 | Request to leave self-refresh |
| ref_req | output | 1 | A refresh is owed and may be granted |
| ref_urgent | output | 1 | Debt has reached the posting limit |
| ref_busy | output | 1 | Refresh cycle time is running |
| sr_active | output | 1 | Device is in self-refresh |
| cmd_block | output | 1 | Non-read commands are held off after exit |
| rd_block | output | 1 | Reads are held off after exit |

## Verification
The hardest state to reach from the ports is a saturated debt that is then drained while interval ticks keep arriving. Tick and grant timing only line up on specific edges, and the debt itself is not visible. The stimulus lets eight intervals pass without any grant, then waits one more interval so that a tick is dropped. After that it holds the grant high, so refreshes are taken every `TRFC_CYC+1` cycles while further ticks are added in. If the extra tick had not been dropped, one more refresh would have been taken, and the bench checks for the quiet cycle that proves it was not. A second sequence grants on the very edge of a tick. A third enters self-refresh while a refresh is still owed, which shows through the port behaviour that entry clears the debt.

// File: rtl/refsched_pkg.sv
`timescale 1ns/1ps
package refsched_pkg;
  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_SELF = 1'b1
  } sr_mode_e;
endpackage

// File: rtl/refi_timer.sv
`timescale 1ns/1ps
// Free-running interval counter; one-cycle tick each PERIOD cycles, frozen on demand.
module refi_timer #(
  parameter int PERIOD = 1560
) (
  input  logic clk,
  input  logic rst,
  input  logic freeze_i,
  output logic tick_o
);
  localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(posedge clk) begin
    if (rst || freeze_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == CNT_W'(PERIOD - 1)) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick_q |=> !tick_q); // R2
  AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    freeze_i |=> !tick_q); // R7
endmodule

// File: rtl/hold_timer.sv
`timescale 1ns/1ps
// Holds active_o high for HOLD_CYC cycles after a start pulse; restart reloads.
module hold_timer #(
  parameter int HOLD_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic active_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (start_i)
      cnt_q <= CNT_W'(HOLD_CYC);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/refresh_debt.sv
`timescale 1ns/1ps
// Saturating count of owed refreshes.
module refresh_debt #(
  parameter int MAX_DEBT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic inc_i,
  input  logic dec_i,
  output logic owed_o,
  output logic full_o
);
  localparam int DEBT_W = $clog2(MAX_DEBT + 1);

  logic [DEBT_W-1:0] debt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      debt_q <= '0;
    else begin
      case ({inc_i, dec_i})
        2'b10: if (debt_q != DEBT_W'(MAX_DEBT)) debt_q <= debt_q + DEBT_W'(1);
        2'b01: if (debt_q != '0) debt_q <= debt_q - DEBT_W'(1);
        default: debt_q <= debt_q;
      endcase
    end
  end

  assign owed_o = (debt_q != '0);
  assign full_o = (debt_q == DEBT_W'(MAX_DEBT));

  AST_DEBT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    debt_q <= DEBT_W'(MAX_DEBT)); // R5
  AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !owed_o); // R7
  AST_DEBT_STEP: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ({1'b0, debt_q} <= {1'b0, $past(debt_q)} + (DEBT_W+1)'(1))); // R2
endmodule

// File: rtl/refresh_sched.sv
`timescale 1ns/1ps
module refresh_sched
  import refsched_pkg::*;
#(
  parameter int TREFI_CYC = 1560,
  parameter int TRFC_CYC  = 8,
  parameter int MAX_DEBT  = 8,
  parameter int TXSNR_CYC = 8,
  parameter int TXSRD_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic all_idle,
  input  logic ref_grant,
  input  logic sr_enter,
  input  logic sr_exit,
  output logic ref_req,
  output logic ref_urgent,
  output logic ref_busy,
  output logic sr_active,
  output logic cmd_block,
  output logic rd_block
);
  sr_mode_e mode_q;
  logic     tick, owed, full, accept, enter_ok, exit_ok;

  assign enter_ok = (mode_q == MODE_RUN) && sr_enter && all_idle && !ref_busy && !cmd_block;
  assign exit_ok  = (mode_q == MODE_SELF) && sr_exit;
  assign ref_req  = owed && !ref_busy && !cmd_block && (mode_q == MODE_RUN);
  assign accept   = ref_grant && ref_req && all_idle;

  always_ff @(posedge clk) begin
    if (rst)            mode_q <= MODE_RUN;
    else if (enter_ok)  mode_q <= MODE_SELF;
    else if (exit_ok)   mode_q <= MODE_RUN;
  end

  assign sr_active  = (mode_q == MODE_SELF);
  assign ref_urgent = full;

  refi_timer #(.PERIOD(TREFI_CYC)) u_timer (
    .clk(clk), .rst(rst), .freeze_i(sr_active || enter_ok), .tick_o(tick)
  );

  refresh_debt #(.MAX_DEBT(MAX_DEBT)) u_debt (
    .clk(clk), .rst(rst), .clr_i(enter_ok), .inc_i(tick || exit_ok),
    .dec_i(accept), .owed_o(owed), .full_o(full)
  );

  hold_timer #(.HOLD_CYC(TRFC_CYC)) u_rfc (
    .clk(clk), .rst(rst), .start_i(accept), .active_o(ref_busy)
  );

  localparam int NBLK = 2;
  localparam int BLK_CYC [NBLK] = '{TXSNR_CYC, TXSRD_CYC};
  logic [NBLK-1:0] blk;
  for (genvar g = 0; g < NBLK; g++) begin : g_exit_blk
    hold_timer #(.HOLD_CYC(BLK_CYC[g])) u_blk (
      .clk(clk), .rst(rst), .start_i(exit_ok), .active_o(blk[g])
    );
  end
  assign cmd_block = blk[0];
  assign rd_block  = blk[1];

  AST_BUSY_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    accept |=> ref_busy); // R4
  AST_GRANT_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (ref_grant && !all_idle) |=> !$rose(ref_busy)); // R3
  AST_EXIT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    exit_ok |=> (cmd_block && rd_block && !sr_active)); // R8
  AST_ENTER_MODE: assert property (@(posedge clk) disable iff (rst)
    enter_ok |=> sr_active); // R7
endmodule

// File: tb/refresh_sched_bench.sv
`timescale 1ns/1ps
module refresh_sched_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic all_idle = 1'b1, ref_grant = 1'b0, sr_enter = 1'b0, sr_exit = 1'b0;
  logic ref_req, ref_urgent, ref_busy, sr_active, cmd_block, rd_block;
  int   vectors = 0;
  int   miscompares = 0;

  always #5 clk = ~clk;

  refresh_sched #(.TREFI_CYC(20), .TRFC_CYC(4), .MAX_DEBT(8), .TXSNR_CYC(3), .TXSRD_CYC(10))
  u_refresh_sched (
    .clk(clk), .rst(rst), .all_idle(all_idle), .ref_grant(ref_grant),
    .sr_enter(sr_enter), .sr_exit(sr_exit), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .ref_busy(ref_busy), .sr_active(sr_active),
    .cmd_block(cmd_block), .rd_block(rd_block)
  );

  // {tag, cycles, idle grant enter exit, req urgent busy sr cmdblk rdblk}
  localparam int NV = 29;
  localparam logic [21:0] VEC [NV] = '{
    {4'd2, 8'd20,  4'b1000, 6'b000000}, // R2 no request before first tick
    {4'd2, 8'd1,   4'b1000, 6'b100000}, // R2 first request
    {4'd3, 8'd1,   4'b0100, 6'b100000}, // R3 grant while not idle ignored
    {4'd4, 8'd1,   4'b1100, 6'b001000}, // R4 grant taken
    {4'd4, 8'd3,   4'b1000, 6'b001000}, // R4 still busy
    {4'd4, 8'd1,   4'b1000, 6'b000000}, // R4 busy ends
    {4'd2, 8'd14,  4'b1000, 6'b100000}, // R2 second tick
    {4'd2, 8'd19,  4'b1000, 6'b100000}, // R2
    {4'd6, 8'd1,   4'b1100, 6'b001000}, // R6 grant on tick edge
    {4'd4, 8'd2,   4'b1100, 6'b001000}, // R4 grants during busy ignored
    {4'd6, 8'd2,   4'b1000, 6'b100000}, // R6 debt kept at one
    {4'd5, 8'd135, 4'b1000, 6'b100000}, // R5 debt seven
    {4'd5, 8'd1,   4'b1000, 6'b110000}, // R5 debt at limit
    {4'd5, 8'd20,  4'b1000, 6'b110000}, // R5 extra tick dropped
    {4'd5, 8'd1,   4'b1100, 6'b001000}, // R5 urgent clears
    {4'd5, 8'd53,  4'b1100, 6'b000000}, // R5 drained with no extra refresh
    {4'd7, 8'd1,   4'b0010, 6'b000000}, // R7 entry refused when not idle
    {4'd2, 8'd5,   4'b1000, 6'b100000}, // R2 one owed again
    {4'd7, 8'd1,   4'b1010, 6'b000100}, // R7 entry accepted
    {4'd7, 8'd100, 4'b1000, 6'b000100}, // R7 frozen, no request
    {4'd8, 8'd1,   4'b1001, 6'b000011}, // R8 exit
    {4'd8, 8'd2,   4'b1000, 6'b000011}, // R8 non-read window
    {4'd8, 8'd1,   4'b1000, 6'b100001}, // R8 owed refresh appears
    {4'd8, 8'd6,   4'b1000, 6'b100001}, // R8 read window
    {4'd8, 8'd1,   4'b1000, 6'b100000}, // R8 read window ends
    {4'd9, 8'd1,   4'b1100, 6'b001000}, // R9 owed refresh taken
    {4'd9, 8'd9,   4'b1000, 6'b000000}, // R9 timer restarted
    {4'd9, 8'd1,   4'b1000, 6'b100000}, // R9 first tick after exit
    {4'd3, 8'd2,   4'b0100, 6'b100000}  // R3 grant ignored again
  };

  function automatic logic [5:0] obs();
    return {ref_req, ref_urgent, ref_busy, sr_active, cmd_block, rd_block};
  endfunction

  task automatic check(input int tag, input logic [5:0] exp);
    vectors++;
    if (obs() !== exp) begin
      miscompares++;
      $display("FAIL R%0d: outputs %b expected %b at %0t", tag, obs(), exp, $time);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1, 6'b000000); // R1 reset state
    rst = 1'b0;
    @(negedge clk);
    check(1, 6'b000000); // R1 first cycle after release
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      {all_idle, ref_grant, sr_enter, sr_exit} = VEC[i][9:6];
      repeat (int'(VEC[i][17:10])) @(posedge clk);
      @(negedge clk);
      check(int'(VEC[i][21:18]), VEC[i][5:0]);
    end
    // R1: reset in mid-operation with a request pending
    {all_idle, ref_grant, sr_enter, sr_exit} = 4'b1000;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(1, 6'b000000); // R1
    rst = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule